// File: doc/BRIEF.md
# Descriptor Ring Engine

This block services a single ring of 16-byte DMA descriptors that sit in host memory. Software sets the ring's base address, the number of slots and a head index; the engine owns a tail index and, while the ring is enabled, works forward from the tail until it meets the head. For each slot it fetches the descriptor in one read through a request/response memory port. It then moves the frame and writes the descriptor back to the same slot with the completed flag set. Finally it emits a one-cycle completion event that carries the descriptor's interrupt request.

Payload movement is shown only as a beat handshake with no data. In transmit mode the engine offers one beat for each byte of the descriptor length and presents the frame delimiters. In receive mode it accepts beats until the source ends the frame or a frame-size limit is hit, and it records the length and delimiters in the written-back descriptor. A raw option suppresses the delimiter fields. A slot that software has not posted is completed as an error, with no beats moved.

Top module: `dring_engine`

## Requirements
- R1: After reset the tail is 0, and no memory request, stream beat or completion is active.
- R2: A descriptor fetch is a read request (`mem_we`=0) to `cfg_base + 16*tail`. A request is held until `mem_gnt`, and each fetch carries exactly one response on `mem_rvalid`.
- R3: No fetch starts while the tail equals `cfg_head`, so an empty ring produces no memory traffic.
- R4: In transmit mode the engine offers exactly `length` beats with `tx_last` on the final one, and none when length is 0. `tx_sof`/`tx_eof` carry the descriptor's SOF/EOF fields, or zero when `cfg_raw` is set.
- R5: The write-back goes to the slot that was fetched. It uses the layout bits [63:0] buffer address, [75:64] length, [79:76] EOF, [83:80] SOF, [95:84] flags and [127:96] time word. Flag bit 1 (completed) is set, the time word is zero, and in transmit mode every other field is unchanged.
- R6: In receive mode a frame ends on `rx_last` or when the beat count reaches the limit, whichever comes first. The limit is `cfg_max_frame`, with 0 treated as 1 and anything above 256 treated as 256. The written-back length is the beat count, and SOF/EOF come from the sideband of the final beat (zero when `cfg_raw` is set). Beats beyond the limit go to the next descriptor.
- R7: A descriptor whose posted flag (bit 2) is clear moves no beats. It is written back with only the completed bit set and the time word cleared, and it completes with `cpl_err`=1.
- R8: Each write-back is followed, one cycle after its grant, by a single-cycle `cpl_valid`. The pulse carries the slot index, flag bit 3 (interrupt request) on `cpl_irq`, and the error indication.
- R9: The tail advances by one at each completion and wraps from `cfg_count-1` to 0.
- R10: While `cfg_enable` is low the engine issues no requests and the tail is forced to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_enable | input | 1 | Ring enable |
| cfg_rx | input | 1 | 1 = receive ring, 0 = transmit ring |
| cfg_raw | input | 1 | Raw mode: delimiter fields forced to zero |
| cfg_base | input | ADDR_W | Byte address of slot 0 |
| cfg_count | input | IDX_W | Number of slots |
| cfg_head | input | IDX_W | First slot not yet posted by software |
| cfg_max_frame | input | 12 | Receive frame-size limit |
| ring_tail | output | IDX_W | Next slot the engine will process |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Request address |
| mem_wdata | output | 128 | Write-back descriptor |
| mem_gnt | input | 1 | Request accepted |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | 128 | Fetched descriptor |
| tx_valid | output | 1 | Transmit beat offered |
| tx_ready | input | 1 | Transmit beat accepted |
| tx_last | output | 1 | Final transmit beat |
| tx_sof | output | 4 | Transmit start-of-frame code |
| tx_eof | output | 4 | Transmit end-of-frame code |
| rx_valid | input | 1 | Receive beat offered |
| rx_ready | output | 1 | Receive beat accepted |
| rx_last | input | 1 | Final receive beat of a frame |
| rx_sof | input | 4 | Receive start-of-frame code |
| rx_eof | input | 4 | Receive end-of-frame code |
| cpl_valid | output | 1 | Completion pulse |
| cpl_index | output | IDX_W | Slot that completed |
| cpl_irq | output | 1 | Interrupt requested by the slot |
| cpl_err | output | 1 | Slot was not posted |

## Verification
A tail register that steps or wraps wrongly shows at the next completion: `cpl_index` and the following fetch address move off the expected slot, and the scoreboard flags this within a few cycles. A beat counter that is off by one shows as a frame whose beat count or `tx_last` position is wrong. In receive mode it also shows as a wrong length in the written-back descriptor, and every receive frame that follows is split at the wrong point. A wrong flag decision, such as a missed posted check or a dropped completed bit, shows up in the write-back data captured at the next memory grant and in the `cpl_err`/`cpl_irq` of the completion pulse one cycle later.

// File: rtl/dring_pkg.sv
package dring_pkg;

  localparam int unsigned DESC_W = 128;
  localparam int unsigned LEN_W  = 12;
  localparam int unsigned DLM_W  = 4;
  localparam int unsigned FLG_W  = 12;

  // flag bit positions inside the descriptor flags field
  localparam int unsigned FLG_ISO    = 0;
  localparam int unsigned FLG_DONE   = 1;
  localparam int unsigned FLG_POSTED = 2;
  localparam int unsigned FLG_IRQ    = 3;

  localparam logic [LEN_W-1:0] FRAME_CAP = 12'h100;

  // first member sits in the top bits
  typedef struct packed {
    logic [31:0]      stamp;
    logic [FLG_W-1:0] flags;
    logic [DLM_W-1:0] sof;
    logic [DLM_W-1:0] eof;
    logic [LEN_W-1:0] len;
    logic [63:0]      buf_addr;
  } desc_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_WAIT,
    ST_MOVE,
    ST_STORE
  } eng_st_t;

  // receive limit: zero behaves as one, large values saturate
  function automatic logic [LEN_W-1:0] eff_limit(input logic [LEN_W-1:0] cfg);
    if (cfg == '0)
      return LEN_W'(1);
    else if (cfg > FRAME_CAP)
      return FRAME_CAP;
    else
      return cfg;
  endfunction

  // descriptor image written back after a slot is handled
  function automatic desc_t writeback(input desc_t d, input logic rx, input logic ok,
                                      input logic [LEN_W-1:0] n,
                                      input logic [DLM_W-1:0] s,
                                      input logic [DLM_W-1:0] e);
    desc_t w;
    w = d;
    if (rx && ok) begin
      w.len = n;
      w.sof = s;
      w.eof = e;
    end
    w.flags[FLG_DONE] = 1'b1;
    w.stamp = '0;
    return w;
  endfunction

endpackage

// File: rtl/dring_tail.sv
module dring_tail #(
  parameter int unsigned IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             advance,
  input  logic [IDX_W-1:0] count,
  input  logic [IDX_W-1:0] head,
  output logic [IDX_W-1:0] tail,
  output logic             empty
);

  function automatic logic [IDX_W-1:0] step(input logic [IDX_W-1:0] t,
                                            input logic [IDX_W-1:0] c);
    return (t == c - 1'b1) ? '0 : t + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      tail <= '0;
    else if (!enable)
      tail <= '0;
    else if (advance)
      tail <= step(tail, count);
  end

  assign empty = (tail == head);

endmodule

// File: rtl/dring_mover.sv
module dring_mover
  import dring_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             abort,
  input  logic             start,
  input  logic             is_rx,
  input  logic             raw,
  input  logic [LEN_W-1:0] tx_len,
  input  logic [DLM_W-1:0] tx_sof_i,
  input  logic [DLM_W-1:0] tx_eof_i,
  input  logic [LEN_W-1:0] limit,
  output logic             tx_valid,
  input  logic             tx_ready,
  output logic             tx_last,
  output logic [DLM_W-1:0] tx_sof,
  output logic [DLM_W-1:0] tx_eof,
  input  logic             rx_valid,
  output logic             rx_ready,
  input  logic             rx_last,
  input  logic [DLM_W-1:0] rx_sof,
  input  logic [DLM_W-1:0] rx_eof,
  output logic             done,
  output logic [LEN_W-1:0] got_len,
  output logic [DLM_W-1:0] got_sof,
  output logic [DLM_W-1:0] got_eof
);

  logic             busy;
  logic             mode_rx;
  logic             raw_q;
  logic [LEN_W-1:0] cnt;
  logic [LEN_W-1:0] goal;
  logic [DLM_W-1:0] sof_q;
  logic [DLM_W-1:0] eof_q;

  logic [LEN_W-1:0] cnt_nx;
  logic             beat;
  logic             last_beat;

  assign cnt_nx    = cnt + 1'b1;
  assign tx_valid  = busy && !mode_rx;
  assign rx_ready  = busy && mode_rx;
  assign beat      = mode_rx ? (rx_valid && rx_ready) : (tx_valid && tx_ready);
  assign last_beat = (cnt_nx == goal) || (mode_rx && rx_last);
  assign tx_last   = tx_valid && (cnt_nx == goal);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      mode_rx <= 1'b0;
      raw_q   <= 1'b0;
      cnt     <= '0;
      goal    <= '0;
      sof_q   <= '0;
      eof_q   <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (abort) begin
        busy <= 1'b0;
      end else if (start) begin
        mode_rx <= is_rx;
        raw_q   <= raw;
        cnt     <= '0;
        goal    <= is_rx ? limit : tx_len;
        sof_q   <= raw ? '0 : tx_sof_i;
        eof_q   <= raw ? '0 : tx_eof_i;
        if (!is_rx && tx_len == '0) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          busy <= 1'b1;
        end
      end else if (busy && beat) begin
        cnt <= cnt_nx;
        if (mode_rx) begin
          sof_q <= raw_q ? '0 : rx_sof;
          eof_q <= raw_q ? '0 : rx_eof;
        end
        if (last_beat) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign tx_sof  = sof_q;
  assign tx_eof  = eof_q;
  assign got_len = cnt;
  assign got_sof = sof_q;
  assign got_eof = eof_q;

endmodule

// File: rtl/dring_engine.sv
module dring_engine
  import dring_pkg::*;
#(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned IDX_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_enable,
  input  logic              cfg_rx,
  input  logic              cfg_raw,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [IDX_W-1:0]  cfg_count,
  input  logic [IDX_W-1:0]  cfg_head,
  input  logic [LEN_W-1:0]  cfg_max_frame,
  output logic [IDX_W-1:0]  ring_tail,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DESC_W-1:0] mem_wdata,
  input  logic              mem_gnt,
  input  logic              mem_rvalid,
  input  logic [DESC_W-1:0] mem_rdata,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic              tx_last,
  output logic [DLM_W-1:0]  tx_sof,
  output logic [DLM_W-1:0]  tx_eof,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic              rx_last,
  input  logic [DLM_W-1:0]  rx_sof,
  input  logic [DLM_W-1:0]  rx_eof,
  output logic              cpl_valid,
  output logic [IDX_W-1:0]  cpl_index,
  output logic              cpl_irq,
  output logic              cpl_err
);

  localparam int unsigned SLOT_SHIFT = $clog2(DESC_W / 8);

  function automatic logic [ADDR_W-1:0] slot_addr(input logic [ADDR_W-1:0] base,
                                                  input logic [IDX_W-1:0]  idx);
    logic [ADDR_W-1:0] off;
    off = ADDR_W'(idx) << SLOT_SHIFT;
    return base + off;
  endfunction

  eng_st_t st, st_nx;
  desc_t   desc_q;
  logic    posted_q;

  // named events for the checker
  logic    rd_fire;
  logic    rsp_take;
  logic    rsp_unposted;
  logic    wr_fire;
  logic    mover_start;
  logic    mover_done;
  logic    ring_empty;
  desc_t   rsp_desc;

  logic [LEN_W-1:0] got_len;
  logic [DLM_W-1:0] got_sof;
  logic [DLM_W-1:0] got_eof;

  assign rsp_desc     = desc_t'(mem_rdata);
  assign rd_fire      = (st == ST_FETCH) && mem_gnt && cfg_enable;
  assign rsp_take     = (st == ST_WAIT) && mem_rvalid && cfg_enable;
  assign rsp_unposted = rsp_take && !rsp_desc.flags[FLG_POSTED];
  assign mover_start  = rsp_take && rsp_desc.flags[FLG_POSTED];
  assign wr_fire      = (st == ST_STORE) && mem_gnt && cfg_enable;

  dring_tail #(.IDX_W(IDX_W)) u_tail (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (cfg_enable),
    .advance (wr_fire),
    .count   (cfg_count),
    .head    (cfg_head),
    .tail    (ring_tail),
    .empty   (ring_empty)
  );

  dring_mover u_mover (
    .clk      (clk),
    .rst_n    (rst_n),
    .abort    (!cfg_enable),
    .start    (mover_start),
    .is_rx    (cfg_rx),
    .raw      (cfg_raw),
    .tx_len   (rsp_desc.len),
    .tx_sof_i (rsp_desc.sof),
    .tx_eof_i (rsp_desc.eof),
    .limit    (eff_limit(cfg_max_frame)),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .tx_last  (tx_last),
    .tx_sof   (tx_sof),
    .tx_eof   (tx_eof),
    .rx_valid (rx_valid),
    .rx_ready (rx_ready),
    .rx_last  (rx_last),
    .rx_sof   (rx_sof),
    .rx_eof   (rx_eof),
    .done     (mover_done),
    .got_len  (got_len),
    .got_sof  (got_sof),
    .got_eof  (got_eof)
  );

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_IDLE:  if (!ring_empty) st_nx = ST_FETCH;
      ST_FETCH: if (mem_gnt) st_nx = ST_WAIT;
      ST_WAIT:  if (mem_rvalid) st_nx = rsp_desc.flags[FLG_POSTED] ? ST_MOVE : ST_STORE;
      ST_MOVE:  if (mover_done) st_nx = ST_STORE;
      ST_STORE: if (mem_gnt) st_nx = ST_IDLE;
      default:  st_nx = ST_IDLE;
    endcase
    if (!cfg_enable) st_nx = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      desc_q   <= '0;
      posted_q <= 1'b0;
    end else begin
      st <= st_nx;
      if (rsp_take) begin
        desc_q   <= rsp_desc;
        posted_q <= rsp_desc.flags[FLG_POSTED];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpl_valid <= 1'b0;
      cpl_index <= '0;
      cpl_irq   <= 1'b0;
      cpl_err   <= 1'b0;
    end else begin
      cpl_valid <= wr_fire;
      if (wr_fire) begin
        cpl_index <= ring_tail;
        cpl_irq   <= desc_q.flags[FLG_IRQ];
        cpl_err   <= !posted_q;
      end
    end
  end

  assign mem_req   = cfg_enable && ((st == ST_FETCH) || (st == ST_STORE));
  assign mem_we    = (st == ST_STORE);
  assign mem_addr  = slot_addr(cfg_base, ring_tail);
  assign mem_wdata = writeback(desc_q, cfg_rx, posted_q, got_len, got_sof, got_eof);

endmodule

// File: rtl/dring_engine_sva.sv
module dring_engine_sva #(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned IDX_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_enable,
  input logic [ADDR_W-1:0] cfg_base,
  input logic [IDX_W-1:0]  cfg_count,
  input logic [IDX_W-1:0]  cfg_head,
  input logic [IDX_W-1:0]  ring_tail,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_gnt,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic              tx_last,
  input logic              rx_ready,
  input logic              cpl_valid,
  input logic [IDX_W-1:0]  cpl_index,
  input logic              wr_fire,
  input logic              rsp_unposted
);

  assert_fetch_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |-> (mem_addr == cfg_base + (ADDR_W'(ring_tail) << 4)));

  assert_req_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> (mem_req || !cfg_enable));

  assert_fetch_needs_work_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req && !mem_we) |-> $past(cfg_enable && (cfg_head != ring_tail)));

  assert_tx_last_ends_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && tx_last) |=> !tx_valid);

  assert_store_same_slot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req && mem_we) |-> (mem_addr == $past(mem_addr)));

  assert_no_beats_unposted_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_unposted |=> (!tx_valid && !rx_ready));

  assert_cpl_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_valid |=> !cpl_valid);

  assert_cpl_after_store_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_valid |-> $past(wr_fire));

  assert_tail_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_valid |-> (ring_tail == ((cpl_index == cfg_count - 1'b1) ? '0 : cpl_index + 1'b1)));

  assert_off_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_enable |=> (ring_tail == '0));

endmodule

bind dring_engine dring_engine_sva #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_sva (.*);

// File: tb/dring_engine_test.sv
module dring_engine_test;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         cfg_enable, cfg_rx, cfg_raw;
  logic [63:0]  cfg_base;
  logic [7:0]   cfg_count, cfg_head;
  logic [11:0]  cfg_max_frame;
  logic [7:0]   ring_tail;
  logic         mem_req, mem_we, mem_gnt, mem_rvalid;
  logic [63:0]  mem_addr;
  logic [127:0] mem_wdata, mem_rdata;
  logic         tx_valid, tx_ready, tx_last;
  logic [3:0]   tx_sof, tx_eof;
  logic         rx_valid, rx_ready, rx_last;
  logic [3:0]   rx_sof, rx_eof;
  logic         cpl_valid, cpl_irq, cpl_err;
  logic [7:0]   cpl_index;

  dring_engine uut (.*);

  always #4 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit ended  = 0;

  task automatic check(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] mk(input logic [63:0] ba, input logic [11:0] len,
                                      input logic [3:0] eof, input logic [3:0] sof,
                                      input logic [11:0] flags, input logic [31:0] tw);
    return {tw, flags, sof, eof, len, ba};
  endfunction

  typedef struct {
    logic [7:0]   idx;
    logic [63:0]  addr;
    logic [127:0] wdata;
    logic         irq;
    logic         err;
    string        tag;
  } exp_t;

  typedef struct {
    int         beats;
    logic [3:0] sof;
    logic [3:0] eof;
  } frm_t;

  exp_t exp_q[$];
  frm_t frm_q[$];
  logic [127:0] mem [logic [63:0]];

  // memory responder
  logic [63:0]  cap_addr;
  logic [127:0] cap_wdata;
  logic         cap_we;
  logic [63:0]  last_wr_addr;
  logic [127:0] last_wr_data;
  initial begin
    int stall = 0;
    mem_gnt = 0; mem_rvalid = 0; mem_rdata = '0;
    cap_addr = '0; cap_wdata = '0; cap_we = 0;
    last_wr_addr = '0; last_wr_data = '0;
    forever begin
      @(negedge clk); #1;
      mem_rvalid = 0;
      if (mem_gnt) begin
        mem_gnt = 0;
        if (cap_we) begin
          mem[cap_addr] = cap_wdata;
        end else begin
          mem_rvalid = 1;
          mem_rdata = mem.exists(cap_addr) ? mem[cap_addr] : '0;
        end
      end else if (mem_req) begin
        stall++;
        if (stall % 2 == 0) begin
          mem_gnt = 1;
          cap_addr = mem_addr; cap_we = mem_we; cap_wdata = mem_wdata;
          if (mem_we) begin last_wr_addr = mem_addr; last_wr_data = mem_wdata; end
        end
      end
    end
  end

  // transmit back-pressure pattern
  initial begin
    int cyc = 0;
    tx_ready = 0;
    forever begin
      @(negedge clk);
      cyc++;
      tx_ready = (cyc % 3 != 2);
    end
  end

  // completion monitor (scoreboard)
  initial begin
    forever begin
      @(negedge clk); #3;
      if (rst_n && cpl_valid) begin
        if (exp_q.size() == 0) begin
          check(0, "R8 unexpected completion", {120'h0, cpl_index}, '0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(last_wr_addr == e.addr && last_wr_data == e.wdata, e.tag,
                last_wr_data, e.wdata);
          check(cpl_index == e.idx && cpl_irq == e.irq && cpl_err == e.err, "R8",
                {118'h0, cpl_err, cpl_irq, cpl_index}, {118'h0, e.err, e.irq, e.idx});
        end
      end
    end
  end

  // transmit monitor
  initial begin
    int beats = 0;
    forever begin
      @(negedge clk); #3;
      if (rst_n && tx_valid && tx_ready) begin
        beats++;
        if (frm_q.size() == 0) begin
          check(0, "R7 beat without posted frame", 128'(beats), '0);
          beats = 0;
        end else if (tx_last) begin
          frm_t f;
          f = frm_q.pop_front();
          check(beats == f.beats && tx_sof == f.sof && tx_eof == f.eof, "R4",
                {beats[15:0], tx_sof, tx_eof}, {f.beats[15:0], f.sof, f.eof});
          beats = 0;
        end
      end
    end
  end

  task automatic post_tx(input int idx, input logic [11:0] len, input logic [3:0] sof,
                         input logic [3:0] eof, input logic [11:0] flags);
    logic [63:0] a;
    exp_t e;
    frm_t f;
    a = cfg_base + 64'(idx * 16);
    mem[a] = mk(64'hA000_0000 + 64'(idx), len, eof, sof, flags, 32'hC0DE_0000 + 32'(idx));
    e.idx = 8'(idx); e.addr = a;
    e.wdata = mk(64'hA000_0000 + 64'(idx), len, eof, sof, flags | 12'h2, 32'h0);
    e.irq = flags[3]; e.err = !flags[2];
    e.tag = flags[2] ? "R5" : "R7";
    exp_q.push_back(e);
    if (flags[2] && len != 0) begin
      f.beats = int'(len);
      f.sof = cfg_raw ? 4'h0 : sof;
      f.eof = cfg_raw ? 4'h0 : eof;
      frm_q.push_back(f);
    end
  endtask

  task automatic post_rx(input int idx, input logic [11:0] flags, input logic [11:0] xlen,
                         input logic [3:0] xsof, input logic [3:0] xeof);
    logic [63:0] a;
    exp_t e;
    a = cfg_base + 64'(idx * 16);
    mem[a] = mk(64'hB000_0000 + 64'(idx), 12'hABC, 4'hE, 4'hD, flags, 32'h5555_0000);
    e.idx = 8'(idx); e.addr = a;
    e.wdata = mk(64'hB000_0000 + 64'(idx), xlen, cfg_raw ? 4'h0 : xeof,
                 cfg_raw ? 4'h0 : xsof, flags | 12'h2, 32'h0);
    e.irq = flags[3]; e.err = 0; e.tag = "R6";
    exp_q.push_back(e);
  endtask

  // receive source: one frame, sideband sof = frame id, eof = beat number
  task automatic send_frame(input int n, input logic [3:0] id);
    for (int i = 1; i <= n; i++) begin
      rx_valid = 1; rx_sof = id; rx_eof = 4'(i); rx_last = (i == n);
      while (!rx_ready) @(negedge clk);
      @(negedge clk);
      rx_valid = 0; rx_last = 0;
    end
  endtask

  task automatic drain();
    while (exp_q.size() != 0 || frm_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    int n;
    rst_n = 0; cfg_enable = 0; cfg_rx = 0; cfg_raw = 0;
    cfg_base = 64'h1000; cfg_count = 8'd4; cfg_head = 8'd0; cfg_max_frame = 12'd4;
    rx_valid = 0; rx_last = 0; rx_sof = 0; rx_eof = 0;
    repeat (5) @(negedge clk);
    #3;
    check(ring_tail == 0 && !mem_req && !cpl_valid && !tx_valid && !rx_ready, "R1",
          {ring_tail, mem_req, cpl_valid, tx_valid, rx_ready}, '0);
    @(negedge clk);
    rst_n = 1;

    // R3: enabled but empty ring stays silent
    cfg_enable = 1;
    n = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); #3; if (mem_req) n++; end
    check(n == 0, "R3 empty ring requests", 128'(n), 0);

    // transmit: three posted slots, one of zero length
    @(negedge clk);
    post_tx(0, 12'd3, 4'h1, 4'h2, 12'h00C);
    post_tx(1, 12'd0, 4'h4, 4'h5, 12'h004);
    post_tx(2, 12'd5, 4'h3, 4'h9, 12'h00C);
    cfg_head = 8'd3;
    drain();
    check(ring_tail == 3, "R9 tail after three", 128'(ring_tail), 3);

    // unposted slot at the end of the ring, head wraps to 0
    post_tx(3, 12'd4, 4'h6, 4'h7, 12'h008);
    cfg_head = 8'd0;
    drain();
    check(ring_tail == 0, "R9 wrap", 128'(ring_tail), 0);

    // raw transmit zeroes delimiters
    cfg_raw = 1;
    post_tx(0, 12'd2, 4'h7, 4'h8, 12'h004);
    cfg_head = 8'd1;
    drain();
    check(ring_tail == 1, "R9 after raw slot", 128'(ring_tail), 1);

    // disable: tail cleared, no traffic although head differs
    cfg_enable = 0;
    repeat (2) @(negedge clk);
    #3;
    check(ring_tail == 0, "R10 tail cleared", 128'(ring_tail), 0);
    n = 0;
    for (int i = 0; i < 10; i++) begin @(negedge clk); #3; if (mem_req || cpl_valid) n++; end
    check(n == 0, "R10 no activity while off", 128'(n), 0);

    // receive with a limit of 4
    @(negedge clk);
    cfg_raw = 0; cfg_rx = 1; cfg_base = 64'h2000; cfg_head = 8'd0; cfg_max_frame = 12'd4;
    post_rx(0, 12'h004, 12'd3, 4'h1, 4'h3);
    post_rx(1, 12'h00C, 12'd4, 4'h2, 4'h4);
    post_rx(2, 12'h004, 12'd2, 4'h2, 4'h6);
    cfg_enable = 1; cfg_head = 8'd3;
    send_frame(3, 4'h1);
    send_frame(6, 4'h2);
    drain();
    check(ring_tail == 3, "R6 tail after receive", 128'(ring_tail), 3);

    // limit above the cap saturates at 256, raw receive
    cfg_raw = 1; cfg_max_frame = 12'h300;
    post_rx(3, 12'h004, 12'h100, 4'h3, 4'h0);
    post_rx(0, 12'h00C, 12'd4, 4'h3, 4'h4);
    cfg_head = 8'd1;
    send_frame(260, 4'h3);
    drain();
    check(ring_tail == 1, "R6 tail after capped frame", 128'(ring_tail), 1);

    finish_run();
  end

endmodule